// File: doc/BRIEF.md
# Ring Frame Strip and Indicator Control

This block sits beside the receive path of a token ring MAC and follows the byte-serial stream one byte-time at a time. A byte strobe marks each byte-time. Two flags on that strobe mark the start delimiter and the end delimiter of a frame. An external address-matching agent drives two levels into the block: an acknowledge level and a strip request level.

The acknowledge level is read at one fixed point only, two byte-times after the end delimiter. If it is high there, the block raises an override flag. The transmitter uses that flag to send the frame's address-recognized indicator as a Set symbol. If it is low, the indicator is repeated as received. The strip request level is read on every byte-time. Three byte-times after it is seen high, a strip flag rises. That flag stops the remaining bytes of the frame from being repeated, and it stays high until the next start delimiter. A board that does not use stripping must tie the strip request low, because a floating input would strip frames at random.

Both delays are parameters. Their defaults are 2 and 3 byte-times.

Top module: `rfs_ring_strip_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the override flag, the strip flag, the acknowledge countdown and any strip request still in flight, so no strip appears after reset from a request seen before it.
- R2: The acknowledge level is sampled on the second byte strobe after the strobe that carries the end delimiter. If it is high there, the override flag reads 1 from the clock after that strobe.
- R3: If the acknowledge level is low at that sample strobe, the override flag stays 0 and the indicator is passed through unchanged.
- R4: The acknowledge level has no effect at any other strobe or cycle, including the first and third strobes after the end delimiter.
- R5: Once set, the override flag holds until the next strobe carrying a start delimiter, which clears it.
- R6: The strip request is sampled on every byte strobe, both inside a frame and between frames.
- R7: When the strip request is high on strobe n, the strip flag reads 1 from the clock after strobe n+3. A request that is high only on cycles without a strobe has no effect.
- R8: The strip flag stays set past the end delimiter and is cleared by the next start-delimiter strobe. If a request reaches its third strobe on that same start-delimiter strobe, the flag is set instead of cleared.
- R9: A strip request held low never raises the strip flag.
- R10: Both outputs change only on clock edges where the byte strobe is high (apart from reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_stb | input | 1 | One-cycle strobe, once per byte-time |
| sd_flag | input | 1 | The current strobe carries a start delimiter |
| ed_flag | input | 1 | The current strobe carries an end delimiter |
| ack_in | input | 1 | Address acknowledge level from the matching agent |
| strip_req | input | 1 | Strip request level from the matching agent |
| ind_set | output | 1 | Transmit the address-recognized indicator as Set |
| strip_active | output | 1 | Strip the rest of the frame (block repeat) |

## Verification
The assertions assume the delimiter flags only have meaning while the strobe is high. They also assume start and end delimiters take turns, so that a fresh end delimiter never arrives while a previous override is still set without a start delimiter in between. The stimulus always builds whole frames: a start-delimiter strobe, a body, an end-delimiter strobe and some idle strobes. It never puts both delimiter flags on the same strobe. Random levels on both agent inputs are applied on strobes and between them, which shows that cycles without a strobe are ignored.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    localparam int unsigned RFS_ACK_DELAY_DEF   = 2;
    localparam int unsigned RFS_STRIP_DELAY_DEF = 3;

    // one byte-time event as seen on the receive side
    typedef struct packed {
        logic stb;
        logic sd;
        logic ed;
    } rfs_sym_t;

    typedef enum logic {
        STRIP_OFF = 1'b0,
        STRIP_ON  = 1'b1
    } rfs_strip_e;

    function automatic logic rfs_is_sd(input rfs_sym_t s);
        return s.stb && s.sd;
    endfunction

    function automatic logic rfs_is_ed(input rfs_sym_t s);
        return s.stb && s.ed && !s.sd;
    endfunction

endpackage

// File: rtl/rfs_ack_sampler.sv
module rfs_ack_sampler
    import rfs_pkg::*;
#(
    parameter int unsigned ACK_DELAY = RFS_ACK_DELAY_DEF
) (
    input  logic     clk,
    input  logic     rst,
    input  rfs_sym_t sym,
    input  logic     ack_in,
    output logic     ind_set
);

    localparam int unsigned CW = $clog2(ACK_DELAY + 1);

    logic [CW-1:0] cnt_q;
    logic          ind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ind_q <= 1'b0;
        end else if (sym.stb) begin
            if (rfs_is_sd(sym)) begin
                cnt_q <= '0;
                ind_q <= 1'b0;
            end else if (rfs_is_ed(sym)) begin
                cnt_q <= CW'(ACK_DELAY);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    ind_q <= ack_in;
                end
            end
        end
    end

    assign ind_set = ind_q;

    // the override can only rise on a strobe that saw acknowledge high
    assert_ind_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ind_set) |-> $past(ack_in && sym.stb));

    // a start-delimiter strobe always leaves the override low
    assert_ind_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (sym.stb && sym.sd) |=> !ind_set);

    // the override only falls on a start delimiter or the sample strobe
    assert_ind_fall_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ind_set) |-> $past(sym.stb && (sym.sd || cnt_q == CW'(1))));

    assert_ind_stable_R10: assert property (@(posedge clk) disable iff (rst)
        !sym.stb |=> $stable(ind_set));

endmodule

// File: rtl/rfs_strip_ctrl.sv
module rfs_strip_ctrl
    import rfs_pkg::*;
#(
    parameter int unsigned STRIP_DELAY = RFS_STRIP_DELAY_DEF
) (
    input  logic     clk,
    input  logic     rst,
    input  rfs_sym_t sym,
    input  logic     strip_req,
    output logic     strip_active
);

    localparam int unsigned LAST = STRIP_DELAY - 1;

    logic [LAST:0] pipe_q;
    logic [LAST:0] pipe_d;
    rfs_strip_e    state_q;

    generate
        if (STRIP_DELAY == 1) begin : g_single
            assign pipe_d = strip_req;
        end else begin : g_chain
            assign pipe_d = {pipe_q[LAST-1:0], strip_req};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q  <= '0;
            state_q <= STRIP_OFF;
        end else if (sym.stb) begin
            pipe_q <= pipe_d;
            if (pipe_q[LAST]) begin
                state_q <= STRIP_ON;
            end else if (rfs_is_sd(sym)) begin
                state_q <= STRIP_OFF;
            end
        end
    end

    assign strip_active = (state_q == STRIP_ON);

    assert_strip_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(strip_active) |-> $past(sym.stb && pipe_q[LAST]));

    // stripping persists through the end delimiter up to a start delimiter
    assert_strip_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (strip_active && !(sym.stb && sym.sd)) |=> strip_active);

    assert_strip_stable_R10: assert property (@(posedge clk) disable iff (rst)
        !sym.stb |=> $stable(strip_active));

    // with no request in flight, the flag cannot rise
    assert_strip_noreq_R9: assert property (@(posedge clk) disable iff (rst)
        (pipe_q == '0 && !strip_active) |=> !strip_active);

endmodule

// File: rtl/rfs_ring_strip_ctrl.sv
module rfs_ring_strip_ctrl
    import rfs_pkg::*;
#(
    parameter int unsigned ACK_DELAY   = RFS_ACK_DELAY_DEF,
    parameter int unsigned STRIP_DELAY = RFS_STRIP_DELAY_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic byte_stb,
    input  logic sd_flag,
    input  logic ed_flag,
    input  logic ack_in,
    input  logic strip_req,
    output logic ind_set,
    output logic strip_active
);

    rfs_sym_t sym;

    assign sym = '{stb: byte_stb, sd: sd_flag, ed: ed_flag};

    rfs_ack_sampler #(
        .ACK_DELAY (ACK_DELAY)
    ) u_ack (
        .clk     (clk),
        .rst     (rst),
        .sym     (sym),
        .ack_in  (ack_in),
        .ind_set (ind_set)
    );

    rfs_strip_ctrl #(
        .STRIP_DELAY (STRIP_DELAY)
    ) u_strip (
        .clk          (clk),
        .rst          (rst),
        .sym          (sym),
        .strip_req    (strip_req),
        .strip_active (strip_active)
    );

    initial begin
        assert_cfg_R2: assert (ACK_DELAY >= 1);
        assert_cfg_R7: assert (STRIP_DELAY >= 1);
    end

endmodule

// File: tb/tb_rfs_ring_strip_ctrl.sv
`timescale 1ns/1ps
module tb_rfs_ring_strip_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic byte_stb = 1'b0, sd_flag = 1'b0, ed_flag = 1'b0;
    logic ack_in = 1'b0, strip_req = 1'b0;
    logic ind_set, strip_active;

    int checks = 0;
    int errors = 0;

    // reference state, built from the requirements
    int   since_ed = -1;
    logic exp_ind = 1'b0;
    logic exp_strip = 1'b0;
    logic [2:0] req_hist = '0;

    always #2.5 clk = ~clk;

    rfs_ring_strip_ctrl dut (
        .clk(clk), .rst(rst), .byte_stb(byte_stb), .sd_flag(sd_flag),
        .ed_flag(ed_flag), .ack_in(ack_in), .strip_req(strip_req),
        .ind_set(ind_set), .strip_active(strip_active)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        since_ed = -1; exp_ind = 1'b0; exp_strip = 1'b0; req_hist = '0;
    endtask

    // strip rises 3 strobes after a request (R7, R8); override follows R2..R5
    task automatic model_step(input logic sd, input logic ed, input logic ack, input logic req);
        if (req_hist[2]) exp_strip = 1'b1;
        else if (sd) exp_strip = 1'b0;
        req_hist = {req_hist[1:0], req};
        if (sd) begin
            since_ed = -1; exp_ind = 1'b0;
        end else if (ed) begin
            since_ed = 0;
        end else if (since_ed >= 0) begin
            since_ed++;
            if (since_ed == 2) begin
                exp_ind = ack; since_ed = -1;
            end
        end
    endtask

    // noise: 0 = quiet, 1 = random levels, 2 = both levels high between strobes
    task automatic strobe(input logic sd, input logic ed, input logic ack, input logic req,
                          input string ti, input string ts, input int gaps, input int noise);
        @(negedge clk);
        sd_flag = sd; ed_flag = ed; ack_in = ack; strip_req = req; byte_stb = 1'b1;
        @(negedge clk);
        byte_stb = 1'b0; sd_flag = 1'b0; ed_flag = 1'b0;
        model_step(sd, ed, ack, req);
        chk(ti, ind_set, exp_ind);
        chk(ts, strip_active, exp_strip);
        for (int g = 0; g < gaps; g++) begin
            case (noise)
                0: begin ack_in = 1'b0; strip_req = 1'b0; end
                1: begin ack_in = 1'($urandom); strip_req = 1'($urandom); end
                default: begin ack_in = 1'b1; strip_req = 1'b1; end
            endcase
            @(negedge clk);
            chk("R10 ind", ind_set, exp_ind);
            chk("R10 strip", strip_active, exp_strip);
        end
        ack_in = 1'b0; strip_req = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; byte_stb = 1'b0;
        @(negedge clk); rst = 1'b0;
        model_clear();
        chk("R1 ind after reset", ind_set, 1'b0);
        chk("R1 strip after reset", strip_active, 1'b0);
    endtask

    task automatic rand_frame();
        int body;
        body = 4 + int'($urandom % 9);
        strobe(1, 0, 1'($urandom), ($urandom % 20) == 0, "R5", "R8", int'($urandom % 3), 1);
        for (int i = 0; i < body; i++)
            strobe(0, 0, 1'($urandom), ($urandom % 20) == 0, "R4", "R6", int'($urandom % 3), 1);
        strobe(0, 1, 1'($urandom), ($urandom % 20) == 0, "R4", "R7", int'($urandom % 3), 1);
        for (int i = 0; i < 2 + int'($urandom % 3); i++)
            strobe(0, 0, 1'($urandom), ($urandom % 20) == 0, "R2", "R7", int'($urandom % 3), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
        chk("R1 ind reset state", ind_set, 1'b0);
        chk("R1 strip reset state", strip_active, 1'b0);

        // R2 and R5: acknowledge high exactly at the sample strobe
        strobe(1, 0, 0, 0, "R5", "R9", 0, 0);
        for (int i = 0; i < 5; i++) strobe(0, 0, 0, 0, "R3", "R9", 1, 0);
        strobe(0, 1, 0, 0, "R2", "R9", 0, 0);
        strobe(0, 0, 0, 0, "R2 first strobe", "R9", 1, 0);
        strobe(0, 0, 1, 0, "R2 sample", "R9", 1, 0);
        chk("R2 ind set", ind_set, 1'b1);
        strobe(0, 0, 0, 0, "R5 hold", "R9", 1, 0);
        strobe(0, 0, 0, 0, "R5 hold", "R9", 0, 0);
        strobe(1, 0, 1, 0, "R5 clear on sd", "R9", 0, 0);
        chk("R5 cleared", ind_set, 1'b0);

        // R3 and R4: acknowledge high around the sample point but low on it
        for (int i = 0; i < 4; i++) strobe(0, 0, 1, 0, "R4", "R9", 1, 2'd2 == 2'd2 ? 0 : 0);
        strobe(0, 1, 1, 0, "R4", "R9", 1, 0);
        strobe(0, 0, 1, 0, "R4 before sample", "R9", 0, 0);
        strobe(0, 0, 0, 0, "R3 sample low", "R9", 2, 0);
        strobe(0, 0, 1, 0, "R4 after sample", "R9", 0, 0);
        chk("R3 indicator untouched", ind_set, 1'b0);

        // R7: levels high only between strobes have no effect
        strobe(1, 0, 0, 0, "R5", "R7", 2, 2);
        for (int i = 0; i < 5; i++) strobe(0, 0, 0, 0, "R4", "R7 gap-only request", 2, 2);
        chk("R7 no strip from gaps", strip_active, 1'b0);

        // R6 and R7: request between frames, after the end delimiter
        strobe(0, 1, 0, 0, "R4", "R7", 0, 0);
        strobe(0, 0, 0, 1, "R3", "R6 request seen", 0, 0);
        strobe(0, 0, 0, 0, "R3", "R7 +1 low", 0, 0);
        strobe(0, 0, 0, 0, "R3", "R7 +2 low", 0, 0);
        strobe(0, 0, 0, 0, "R3", "R7 +3 high", 0, 0);
        chk("R7 strip on third strobe", strip_active, 1'b1);
        strobe(0, 0, 0, 0, "R3", "R8 hold", 1, 0);
        strobe(1, 0, 0, 0, "R5", "R8 clear on sd", 0, 0);
        chk("R8 cleared", strip_active, 1'b0);

        // R6 and R8: request in a frame body, held over the end delimiter
        strobe(0, 0, 0, 1, "R4", "R6 in body", 0, 0);
        for (int i = 0; i < 3; i++) strobe(0, 0, 0, 0, "R4", "R7", 0, 0);
        strobe(0, 1, 0, 0, "R4", "R8 through ed", 0, 0);
        chk("R8 stays over ed", strip_active, 1'b1);
        strobe(0, 0, 0, 0, "R3", "R8", 0, 0);
        // R8: request maturing on the start-delimiter strobe wins
        strobe(0, 0, 0, 1, "R3", "R8", 0, 0);
        strobe(0, 0, 0, 0, "R3", "R8", 0, 0);
        strobe(0, 0, 0, 0, "R3", "R8", 0, 0);
        strobe(1, 0, 0, 0, "R5", "R8 set wins", 0, 0);
        chk("R8 set over clear", strip_active, 1'b1);
        strobe(1, 0, 0, 0, "R5", "R8 next sd clears", 0, 0);

        // R9: request tied low for a long stretch
        for (int i = 0; i < 40; i++) strobe(i == 0, i == 30, 1'($urandom), 0, "R2", "R9 tied low", 1, 0);
        chk("R9 never strips", strip_active, 1'b0);

        // R1: request in flight is dropped by reset
        strobe(1, 0, 0, 1, "R5", "R6", 0, 0);
        do_reset();
        for (int i = 0; i < 4; i++) strobe(0, 0, 0, 0, "R1", "R1 no stale strip", 0, 0);
        chk("R1 pending request dropped", strip_active, 1'b0);

        // constrained random frames
        for (int f = 0; f < 150; f++) rand_frame();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule